// File: doc/BRIEF.md
# Byte Transfer Buffer with Per-Byte Interrupt

This block is the small byte buffer that sits between a host register port and a pseudo-DMA port in a storage bus controller. A write pointer and a read pointer index a byte RAM, and a signed remaining-size counter runs next to them. The buffer does not wrap. Whenever a read leaves the read pointer equal to the write pointer, both pointers return to slot zero. The host loads bytes one at a time through a FIFO register and reads them back the same way. A command register holds the last command written. A flush command empties the pointers without touching the size counter, and a byte-count output always shows how many bytes the buffer holds.

The pseudo-DMA port moves one or two bytes per access. In a two-byte access the first byte travels in the upper half. The port reports when a read drains the buffer and when a write fills it to capacity. A status-load input places a two-byte status response (the status byte, then a zero) at the head of the buffer. When the command register holds the non-DMA transfer command, every host byte written raises the function-complete and bus-service reasons together with the interrupt line. An acknowledge input clears all three.

Only one request is expected per cycle. If several arrive together, the arbiter takes them in this order: flush, status load, host write, host read, pseudo-DMA read, pseudo-DMA write.

Top module: `bytebuf_fifo`

## Requirements
- R1: After reset, `flags` and `size_cnt` are 0, `hst_rdata` and `pdma_rdata` are 0, and `irq`, `rsn_fc`, `rsn_bs`, `drain_done` and `fill_done` are 0.
- R2: A host write (`hst_wr`) while the write pointer is not DEPTH-1 stores `hst_wdata`. It raises `flags` by one and `size_cnt` by one.
- R3: A host write while the write pointer equals DEPTH-1 is an overrun. The byte is dropped, and `flags`, `size_cnt` and the stored bytes are left unchanged.
- R4: A host read (`hst_rd`) while bytes are held, with `phase` not 3'b000, places the oldest byte on `hst_rdata` one cycle later. It lowers `flags` and `size_cnt` by one each. A read of an empty buffer leaves `hst_rdata` unchanged.
- R5: A read that makes the read pointer equal the write pointer resets both pointers to 0. After that, DEPTH-1 further host writes are all accepted.
- R6: A host read while `phase` is 3'b000 (data-out) returns 0x00 and leaves `flags` and `size_cnt` unchanged.
- R7: Writing a command whose bits [6:0] are 0x01 is a flush, whatever bit 7 holds. It resets both pointers (`flags` becomes 0) and leaves `size_cnt` unchanged.
- R8: While the command register holds exactly 0x10, every host write sets `irq`, `rsn_fc` and `rsn_bs` one cycle later. `int_ack` clears all three. With any other command (for example 0x90), a host write leaves them at 0.
- R9: A pseudo-DMA read with `pdma_wide`=1 returns {oldest byte, next byte} on `pdma_rdata` and advances the read pointer by two. With `pdma_wide`=0 it returns {8'h00, oldest byte}. Pseudo-DMA reads do not change `size_cnt`.
- R10: A pseudo-DMA read that empties the buffer resets both pointers and pulses `drain_done` for one cycle.
- R11: A pseudo-DMA write stores `pdma_wdata[15:8]` first and then `pdma_wdata[7:0]` when `pdma_wide`=1. It does not change `size_cnt`. When the write pointer reaches DEPTH, `fill_done` pulses for one cycle.
- R12: A status load (`stat_ld`) puts `stat_byte` in slot 0 and 0x00 in slot 1. It sets the write pointer to 2 and the read pointer to 0, so `flags` becomes 2, and it sets `size_cnt` to 2.
- R13: `flags` always equals the write pointer minus the read pointer, and the read pointer never passes the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command value; bit 7 is the DMA flag |
| phase | input | 3 | Bus phase bits; 3'b000 is data-out |
| hst_wr | input | 1 | Host FIFO register write |
| hst_wdata | input | 8 | Host write byte |
| hst_rd | input | 1 | Host FIFO register read |
| hst_rdata | output | 8 | Host read byte, valid one cycle after the read |
| int_ack | input | 1 | Clears the interrupt and its reasons |
| stat_ld | input | 1 | Load a two-byte status response |
| stat_byte | input | 8 | Status byte for the response |
| pdma_rd | input | 1 | Pseudo-DMA read request |
| pdma_wr | input | 1 | Pseudo-DMA write request |
| pdma_wide | input | 1 | Pseudo-DMA access is two bytes |
| pdma_wdata | input | 16 | Pseudo-DMA write data |
| pdma_rdata | output | 16 | Pseudo-DMA read data |
| flags | output | $clog2(DEPTH)+1 | Byte count held in the buffer |
| size_cnt | output | SIZE_W | Signed remaining-size counter |
| irq | output | 1 | Interrupt request |
| rsn_fc | output | 1 | Function-complete reason |
| rsn_bs | output | 1 | Bus-service reason |
| drain_done | output | 1 | Pulse: pseudo-DMA read emptied the buffer |
| fill_done | output | 1 | Pulse: pseudo-DMA write filled the buffer |

## Verification
Every output is registered. Each result therefore appears in the cycle after the rising edge that samples its request, and the two pulses last exactly that one cycle. The bench applies each request at a falling edge and removes it at the next falling edge, which comes just after the sampling rising edge. It reads every output at that falling edge. With this timing, a single sample catches each pulse and each new count, and it catches them before any later request can change them.

// File: rtl/bytebuf_pkg.sv
package bytebuf_pkg;

   // command opcodes in bits [6:0] of the command register
   localparam logic [6:0] OP_FLUSH = 7'h01;
   localparam logic [6:0] OP_XFER  = 7'h10;

   // full command value for a programmed-I/O transfer (DMA flag clear)
   localparam logic [7:0] CMD_XFER_PIO = {1'b0, OP_XFER};

   // phase encoding on which host reads return zero
   localparam logic [2:0] PH_DATA_OUT = 3'b000;

   // one buffer action per cycle, chosen by the arbiter
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_FLUSH,
      ACT_STAT,
      ACT_HWR,
      ACT_HRD,
      ACT_PRD,
      ACT_PWR
   } act_e;

endpackage

// File: rtl/bytebuf_arb.sv
module bytebuf_arb
   import bytebuf_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [6:0] cmd_op,
   input  logic       stat_ld,
   input  logic       hst_wr,
   input  logic       hst_rd,
   input  logic       pdma_rd,
   input  logic       pdma_wr,
   output act_e       act
);

   logic flush_req;
   assign flush_req = cmd_wr && (cmd_op == OP_FLUSH);

   always_comb begin
      if (flush_req)     act = ACT_FLUSH;
      else if (stat_ld)  act = ACT_STAT;
      else if (hst_wr)   act = ACT_HWR;
      else if (hst_rd)   act = ACT_HRD;
      else if (pdma_rd)  act = ACT_PRD;
      else if (pdma_wr)  act = ACT_PWR;
      else               act = ACT_IDLE;
   end

endmodule

// File: rtl/bytebuf_store.sv
module bytebuf_store #(
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we0,
   input  logic [AW-1:0] wa0,
   input  logic [7:0]    wd0,
   input  logic          we1,
   input  logic [AW-1:0] wa1,
   input  logic [7:0]    wd1,
   input  logic [AW-1:0] ra0,
   output logic [7:0]    rd0,
   input  logic [AW-1:0] ra1,
   output logic [7:0]    rd1
);

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else begin
               if (we0) mem[wa0] <= wd0;
               if (we1) mem[wa1] <= wd1;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we0) mem[wa0] <= wd0;
            if (we1) mem[wa1] <= wd1;
         end
      end
   endgenerate

   assign rd0 = mem[ra0];
   assign rd1 = mem[ra1];

endmodule

// File: rtl/bytebuf_ptrs.sv
module bytebuf_ptrs
   import bytebuf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int SIZE_W = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int PTR_W = AW + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  act_e                     act,
   input  logic [7:0]               hst_wdata,
   input  logic [2:0]               phase,
   input  logic [7:0]               stat_byte,
   input  logic                     pdma_wide,
   input  logic [15:0]              pdma_wdata,
   input  logic [7:0]               rd0,
   input  logic [7:0]               rd1,
   output logic                     we0,
   output logic [AW-1:0]            wa0,
   output logic [7:0]               wd0,
   output logic                     we1,
   output logic [AW-1:0]            wa1,
   output logic [7:0]               wd1,
   output logic [AW-1:0]            ra0,
   output logic [AW-1:0]            ra1,
   output logic [PTR_W-1:0]         wp,
   output logic [PTR_W-1:0]         rp,
   output logic signed [SIZE_W-1:0] size_cnt,
   output logic [7:0]               hst_rdata,
   output logic [15:0]              pdma_rdata,
   output logic                     drain_done,
   output logic                     fill_done
);

   localparam logic [PTR_W-1:0] P_LAST = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W-1:0] P_FULL = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] P_ONE  = PTR_W'(1);
   localparam logic [PTR_W-1:0] P_TWO  = PTR_W'(2);

   logic [PTR_W-1:0]         wp_n, rp_n, wp_inc;
   logic signed [SIZE_W-1:0] sz_n;
   logic [7:0]               hrd_n;
   logic [15:0]              prd_n;
   logic                     drain_n, fill_n;

   assign ra0    = rp[AW-1:0];
   assign ra1    = rp[AW-1:0] + AW'(1);
   assign wp_inc = wp + P_ONE;

   always_comb begin
      wp_n    = wp;
      rp_n    = rp;
      sz_n    = size_cnt;
      hrd_n   = hst_rdata;
      prd_n   = pdma_rdata;
      drain_n = 1'b0;
      fill_n  = 1'b0;
      we0     = 1'b0;
      wa0     = wp[AW-1:0];
      wd0     = hst_wdata;
      we1     = 1'b0;
      wa1     = wp[AW-1:0] + AW'(1);
      wd1     = pdma_wdata[7:0];
      unique case (act)
         ACT_FLUSH: begin
            wp_n = '0;
            rp_n = '0;
         end
         ACT_STAT: begin
            we0  = 1'b1;
            wa0  = '0;
            wd0  = stat_byte;
            we1  = 1'b1;
            wa1  = AW'(1);
            wd1  = 8'h00;
            wp_n = P_TWO;
            rp_n = '0;
            sz_n = SIZE_W'(2);
         end
         ACT_HWR: begin
            if (wp != P_LAST) begin
               we0  = 1'b1;
               wp_n = wp_inc;
               sz_n = size_cnt + SIZE_W'(1);
            end
         end
         ACT_HRD: begin
            if (phase == PH_DATA_OUT) begin
               hrd_n = 8'h00;
            end else if (rp < wp) begin
               hrd_n = rd0;
               rp_n  = rp + P_ONE;
               sz_n  = size_cnt - SIZE_W'(1);
            end
            if (rp_n == wp_n) begin
               rp_n = '0;
               wp_n = '0;
            end
         end
         ACT_PRD: begin
            prd_n = pdma_wide ? {rd0, rd1} : {8'h00, rd0};
            rp_n  = rp + (pdma_wide ? P_TWO : P_ONE);
            if (rp_n == wp) begin
               rp_n    = '0;
               wp_n    = '0;
               drain_n = 1'b1;
            end
         end
         ACT_PWR: begin
            we0  = (wp < P_FULL);
            wd0  = pdma_wide ? pdma_wdata[15:8] : pdma_wdata[7:0];
            we1  = pdma_wide && (wp_inc < P_FULL);
            wp_n = wp + PTR_W'(we0) + PTR_W'(we1);
            fill_n = (we0 || we1) && (wp_n == P_FULL);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp         <= '0;
         rp         <= '0;
         size_cnt   <= '0;
         hst_rdata  <= '0;
         pdma_rdata <= '0;
         drain_done <= 1'b0;
         fill_done  <= 1'b0;
      end else begin
         wp         <= wp_n;
         rp         <= rp_n;
         size_cnt   <= sz_n;
         hst_rdata  <= hrd_n;
         pdma_rdata <= prd_n;
         drain_done <= drain_n;
         fill_done  <= fill_n;
      end
   end

endmodule

// File: rtl/bytebuf_intr.sv
module bytebuf_intr
   import bytebuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_code,
   input  logic       hst_wr,
   input  logic       int_ack,
   output logic [7:0] cmd_q,
   output logic       irq,
   output logic       rsn_fc,
   output logic       rsn_bs
);

   logic pio_byte;
   assign pio_byte = hst_wr && (cmd_q == CMD_XFER_PIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         irq    <= 1'b0;
         rsn_fc <= 1'b0;
         rsn_bs <= 1'b0;
      end else begin
         if (cmd_wr) cmd_q <= cmd_code;
         if (pio_byte) begin
            irq    <= 1'b1;
            rsn_fc <= 1'b1;
            rsn_bs <= 1'b1;
         end else if (int_ack) begin
            irq    <= 1'b0;
            rsn_fc <= 1'b0;
            rsn_bs <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/bytebuf_fifo.sv
module bytebuf_fifo
   import bytebuf_pkg::*;
#(
   parameter int DEPTH          = 16,
   parameter int SIZE_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_wr,
   input  logic [7:0]                  cmd_code,
   input  logic [2:0]                  phase,
   input  logic                        hst_wr,
   input  logic [7:0]                  hst_wdata,
   input  logic                        hst_rd,
   output logic [7:0]                  hst_rdata,
   input  logic                        int_ack,
   input  logic                        stat_ld,
   input  logic [7:0]                  stat_byte,
   input  logic                        pdma_rd,
   input  logic                        pdma_wr,
   input  logic                        pdma_wide,
   input  logic [15:0]                 pdma_wdata,
   output logic [15:0]                 pdma_rdata,
   output logic [$clog2(DEPTH):0]      flags,
   output logic signed [SIZE_W-1:0]    size_cnt,
   output logic                        irq,
   output logic                        rsn_fc,
   output logic                        rsn_bs,
   output logic                        drain_done,
   output logic                        fill_done
);

   localparam int AW    = $clog2(DEPTH);
   localparam int PTR_W = AW + 1;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         initial $fatal(1, "bytebuf_fifo: DEPTH must be a power of two of at least 4");
      end
      if (SIZE_W < PTR_W + 1) begin : g_bad_size
         initial $fatal(1, "bytebuf_fifo: SIZE_W too narrow for DEPTH");
      end
   endgenerate

   act_e             act;
   logic             we0, we1;
   logic [AW-1:0]    wa0, wa1, ra0, ra1;
   logic [7:0]       wd0, wd1, rd0, rd1;
   logic [PTR_W-1:0] wp, rp;
   logic [7:0]       cmd_q;

   bytebuf_arb u_arb (
      .cmd_wr  (cmd_wr),
      .cmd_op  (cmd_code[6:0]),
      .stat_ld (stat_ld),
      .hst_wr  (hst_wr),
      .hst_rd  (hst_rd),
      .pdma_rd (pdma_rd),
      .pdma_wr (pdma_wr),
      .act     (act)
   );

   bytebuf_store #(.DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk (clk), .rst_n (rst_n),
      .we0 (we0), .wa0 (wa0), .wd0 (wd0),
      .we1 (we1), .wa1 (wa1), .wd1 (wd1),
      .ra0 (ra0), .rd0 (rd0),
      .ra1 (ra1), .rd1 (rd1)
   );

   bytebuf_ptrs #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .hst_wdata  (hst_wdata),
      .phase      (phase),
      .stat_byte  (stat_byte),
      .pdma_wide  (pdma_wide),
      .pdma_wdata (pdma_wdata),
      .rd0        (rd0),
      .rd1        (rd1),
      .we0        (we0),
      .wa0        (wa0),
      .wd0        (wd0),
      .we1        (we1),
      .wa1        (wa1),
      .wd1        (wd1),
      .ra0        (ra0),
      .ra1        (ra1),
      .wp         (wp),
      .rp         (rp),
      .size_cnt   (size_cnt),
      .hst_rdata  (hst_rdata),
      .pdma_rdata (pdma_rdata),
      .drain_done (drain_done),
      .fill_done  (fill_done)
   );

   bytebuf_intr u_intr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_code (cmd_code),
      .hst_wr   (hst_wr),
      .int_ack  (int_ack),
      .cmd_q    (cmd_q),
      .irq      (irq),
      .rsn_fc   (rsn_fc),
      .rsn_bs   (rsn_bs)
   );

   assign flags = wp - rp;

endmodule

// File: rtl/bytebuf_chk.sv
module bytebuf_chk
   import bytebuf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int SIZE_W = 16,
   parameter int PTR_W  = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cmd_wr,
   input logic [6:0]               cmd_op,
   input logic                     stat_ld,
   input logic                     hst_wr,
   input logic [PTR_W-1:0]         wp,
   input logic [PTR_W-1:0]         rp,
   input logic [PTR_W-1:0]         flags,
   input logic signed [SIZE_W-1:0] size_cnt,
   input logic [7:0]               cmd_q,
   input logic                     irq,
   input logic                     rsn_fc,
   input logic                     rsn_bs,
   input logic                     drain_done,
   input logic                     fill_done
);

   localparam logic [PTR_W-1:0] C_LAST = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W-1:0] C_FULL = PTR_W'(DEPTH);

   logic flush_cmd;
   assign flush_cmd = cmd_wr && (cmd_op == OP_FLUSH);

   // R13: read pointer never passes write pointer
   a_r13_rp_behind_wp: assert property (@(posedge clk) disable iff (!rst_n)
      rp <= wp);

   // R2: accepted host write counts up
   a_r2_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && !cmd_wr && !stat_ld && wp != C_LAST)
      |=> size_cnt == $past(size_cnt) + SIZE_W'(1));

   // R3: overrun write changes nothing
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && !cmd_wr && !stat_ld && wp == C_LAST)
      |=> (wp == $past(wp)) && (size_cnt == $past(size_cnt)));

   // R7: flush empties pointers and keeps the size counter
   a_r7_flush_keeps_size: assert property (@(posedge clk) disable iff (!rst_n)
      flush_cmd |=> (flags == '0) && $stable(size_cnt));

   // R8: per-byte interrupt in programmed-I/O transfer
   a_r8_irq_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && cmd_q == CMD_XFER_PIO) |=> (irq && rsn_fc && rsn_bs));

   // R10: drain pulse only with both pointers at zero
   a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> (wp == '0) && (rp == '0));

   // R11: fill pulse only at capacity
   a_r11_fill_full: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (wp == C_FULL));

   // R12: status load leaves two bytes
   a_r12_status_two: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_ld && !flush_cmd) |=> (flags == PTR_W'(2)) && (size_cnt == SIZE_W'(2)));

endmodule

bind bytebuf_fifo bytebuf_chk #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_wr     (cmd_wr),
   .cmd_op     (cmd_code[6:0]),
   .stat_ld    (stat_ld),
   .hst_wr     (hst_wr),
   .wp         (wp),
   .rp         (rp),
   .flags      (flags),
   .size_cnt   (size_cnt),
   .cmd_q      (cmd_q),
   .irq        (irq),
   .rsn_fc     (rsn_fc),
   .rsn_bs     (rsn_bs),
   .drain_done (drain_done),
   .fill_done  (fill_done)
);

// File: tb/tb_bytebuf_fifo.sv
module tb_bytebuf_fifo;

   localparam int  DEPTH   = 16;
   localparam int  SIZE_W  = 16;
   localparam time CLK_PER = 10ns;
   localparam int  WD_CYC  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 0, hst_wr = 0, hst_rd = 0, int_ack = 0, stat_ld = 0;
   logic        pdma_rd = 0, pdma_wr = 0, pdma_wide = 0;
   logic [7:0]  cmd_code = 0, hst_wdata = 0, stat_byte = 0;
   logic [2:0]  phase = 3'b001;
   logic [15:0] pdma_wdata = 0;
   logic [7:0]  hst_rdata;
   logic [15:0] pdma_rdata;
   logic [4:0]  flags;
   logic signed [SIZE_W-1:0] size_cnt;
   logic        irq, rsn_fc, rsn_bs, drain_done, fill_done;

   int nchk = 0;
   int nerr = 0;
   int sz_exp = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   bytebuf_fifo #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) dut (.*);

   typedef struct packed {
      logic [1:0]  op;   // 0 host write, 1 host read, 2 flush
      logic [7:0]  dat;
      logic [4:0]  fl;
      logic [15:0] sz;
      logic [7:0]  rd;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{2'd0, 8'hA1, 5'd1, 16'd1, 8'h00},
      '{2'd0, 8'hB2, 5'd2, 16'd2, 8'h00},
      '{2'd0, 8'hC3, 5'd3, 16'd3, 8'h00},
      '{2'd1, 8'h00, 5'd2, 16'd2, 8'hA1},
      '{2'd0, 8'hD4, 5'd3, 16'd3, 8'hA1},
      '{2'd1, 8'h00, 5'd2, 16'd2, 8'hB2},
      '{2'd1, 8'h00, 5'd1, 16'd1, 8'hC3},
      '{2'd1, 8'h00, 5'd0, 16'd0, 8'hD4},
      '{2'd0, 8'h5E, 5'd1, 16'd1, 8'hD4},
      '{2'd2, 8'h01, 5'd0, 16'd1, 8'hD4},
      '{2'd0, 8'h6F, 5'd1, 16'd2, 8'hD4},
      '{2'd1, 8'h00, 5'd0, 16'd1, 8'h6F}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
   endtask

   task automatic hwr(input logic [7:0] d);
      @(negedge clk); hst_wr = 1; hst_wdata = d;
      @(negedge clk); hst_wr = 0;
   endtask

   task automatic hrd();
      @(negedge clk); hst_rd = 1;
      @(negedge clk); hst_rd = 0;
   endtask

   task automatic cmd(input logic [7:0] c);
      @(negedge clk); cmd_wr = 1; cmd_code = c;
      @(negedge clk); cmd_wr = 0;
   endtask

   task automatic ack();
      @(negedge clk); int_ack = 1;
      @(negedge clk); int_ack = 0;
   endtask

   task automatic prd(input logic w);
      @(negedge clk); pdma_rd = 1; pdma_wide = w;
      @(negedge clk); pdma_rd = 0; pdma_wide = 0;
   endtask

   task automatic pwr(input logic w, input logic [15:0] d);
      @(negedge clk); pdma_wr = 1; pdma_wide = w; pdma_wdata = d;
      @(negedge clk); pdma_wr = 0; pdma_wide = 0;
   endtask

   task automatic sld(input logic [7:0] s);
      @(negedge clk); stat_ld = 1; stat_byte = s;
      @(negedge clk); stat_ld = 0;
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flags", flags, 0);
      chk("R1 size", size_cnt, 0);
      chk("R1 rdata", {hst_rdata, pdma_rdata}, 0);
      chk("R1 irq/reasons/pulses", {irq, rsn_fc, rsn_bs, drain_done, fill_done}, 0);

      // table walk: R2 writes, R4 reads, R5 empty reset, R7 flush, R13 count
      for (int i = 0; i < 12; i++) begin
         case (TBL[i].op)
            2'd0: hwr(TBL[i].dat);
            2'd1: hrd();
            default: cmd(TBL[i].dat);
         endcase
         chk(TBL[i].op == 2'd0 ? "R2/R13 write" : TBL[i].op == 2'd1 ? "R4/R13 read" : "R7 flush",
             {flags, size_cnt, hst_rdata}, {TBL[i].fl, TBL[i].sz, TBL[i].rd});
      end
      sz_exp = 1;

      // R3 overrun at DEPTH-1, flush with DMA bit set (R7)
      cmd(8'h81);
      chk("R7 flush dma bit", {flags, size_cnt}, {5'd0, 16'(sz_exp)});
      for (int i = 0; i < DEPTH - 1; i++) hwr(8'h10 + 8'(i));
      sz_exp += DEPTH - 1;
      chk("R2 fill to DEPTH-1", {flags, size_cnt}, {5'd15, 16'(sz_exp)});
      hwr(8'hEE);
      chk("R3 overrun dropped", {flags, size_cnt}, {5'd15, 16'(sz_exp)});
      for (int i = 0; i < DEPTH - 1; i++) hrd();
      sz_exp -= DEPTH - 1;
      chk("R3 last stored byte", hst_rdata, 8'h1E);
      chk("R5 drained", {flags, size_cnt}, {5'd0, 16'(sz_exp)});

      // R5 pointers back at zero: DEPTH-1 writes accepted again
      for (int i = 0; i < DEPTH - 1; i++) hwr(8'h40 + 8'(i));
      sz_exp += DEPTH - 1;
      chk("R5 refill accepted", {flags, size_cnt}, {5'd15, 16'(sz_exp)});
      cmd(8'h01);
      chk("R7 flush keeps size", {flags, size_cnt}, {5'd0, 16'(sz_exp)});

      // R6 data-out phase read
      hwr(8'h77); hwr(8'h88); sz_exp += 2;
      phase = 3'b000;
      hrd();
      chk("R6 data-out read", {hst_rdata, flags, size_cnt}, {8'h00, 5'd2, 16'(sz_exp)});
      phase = 3'b001;
      hrd(); sz_exp -= 1;
      chk("R4 read after data-out", {hst_rdata, flags, size_cnt}, {8'h77, 5'd1, 16'(sz_exp)});
      hrd(); sz_exp -= 1;
      chk("R4 second read", {hst_rdata, flags}, {8'h88, 5'd0});

      // R8 per-byte interrupt
      cmd(8'h10);
      chk("R8 no irq before write", {irq, rsn_fc, rsn_bs}, 3'b000);
      hwr(8'h31); sz_exp += 1;
      chk("R8 irq on pio write", {irq, rsn_fc, rsn_bs}, 3'b111);
      ack();
      chk("R8 ack clears", {irq, rsn_fc, rsn_bs}, 3'b000);
      hwr(8'h32); sz_exp += 1;
      chk("R8 irq on each byte", {irq, rsn_fc, rsn_bs}, 3'b111);
      ack();
      cmd(8'h90);
      hwr(8'h33); sz_exp += 1;
      chk("R8 no irq with dma xfer", {irq, rsn_fc, rsn_bs}, 3'b000);
      cmd(8'h00);

      // R9 / R10 pseudo-DMA reads
      cmd(8'h01);
      hwr(8'h11); hwr(8'h22); hwr(8'h33); sz_exp += 3;
      prd(1'b1);
      chk("R9 wide read", {pdma_rdata, flags, drain_done}, {16'h1122, 5'd1, 1'b0});
      chk("R9 size untouched", size_cnt, 16'(sz_exp));
      prd(1'b0);
      chk("R10 narrow read drains", {pdma_rdata, flags, drain_done}, {16'h0033, 5'd0, 1'b1});
      @(negedge clk);
      chk("R10 drain one cycle", drain_done, 1'b0);

      // R11 pseudo-DMA writes
      pwr(1'b1, 16'hABCD);
      chk("R11 wide write", {flags, size_cnt, fill_done}, {5'd2, 16'(sz_exp), 1'b0});
      hrd(); sz_exp -= 1;
      chk("R11 upper byte first", hst_rdata, 8'hAB);
      hrd(); sz_exp -= 1;
      chk("R11 lower byte second", {hst_rdata, flags}, {8'hCD, 5'd0});
      for (int i = 1; i < 8; i++) pwr(1'b1, 16'h0101 * 16'(i));
      chk("R11 not yet full", {flags, fill_done}, {5'd14, 1'b0});
      pwr(1'b1, 16'hF0F1);
      chk("R11 fill pulse", {flags, fill_done, size_cnt}, {5'd16, 1'b1, 16'(sz_exp)});
      @(negedge clk);
      chk("R11 fill one cycle", fill_done, 1'b0);
      cmd(8'h01);

      // R12 status response
      sld(8'h5A);
      chk("R12 status load", {flags, size_cnt}, {5'd2, 16'd2});
      hrd();
      chk("R12 status byte", hst_rdata, 8'h5A);
      hrd();
      chk("R12 trailing zero", {hst_rdata, flags, size_cnt}, {8'h00, 5'd0, 16'd0});

      done = 1;
      summary();
      $finish;
   end

endmodule